// File: doc/BRIEF.md
# MIDI Note Message Parser

This block sits behind a serial byte receiver and turns the raw MIDI byte stream into decoded note events. Each received byte arrives with a one-cycle strobe, at any spacing. The parser tracks the current running status, collects the key number and velocity data bytes, and emits one note record per complete message. A note record holds an on/off flag, a 4-bit channel, a 7-bit key and a 7-bit velocity.

Other channel-voice and system messages are only classified, so that their data bytes can be skipped. Timing clock and other real-time bytes may appear anywhere, even inside a message, and are passed over without effect. A note-on that carries velocity zero is reported as a note-off.

Completed records leave through a valid/ready handshake. The output register is backed by a one-entry holding register, so parsing can go on while the consumer stalls.

Top module: `midi_note_parser`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is low and no running status exists, so data bytes are discarded until a note status byte arrives.
- R2: A status byte 0x9n (bits 7..4 = 1001) followed by two data bytes (bit 7 = 0), key then velocity, with velocity nonzero, yields a record with on = 1, channel = n (bits 3..0 of the status), key and velocity equal to the data bytes' low 7 bits. `out_valid` rises in the cycle after the edge that captures the velocity byte's strobe.
- R3: A status byte 0x8n (bits 7..4 = 1000) followed by key and velocity yields a record with on = 0, channel n, and the key and velocity unchanged.
- R4: A note-on message with velocity 0 yields a record with on = 0 and velocity 0.
- R5: After a note status byte, each further pair of data bytes with no status byte in between yields another record of the same type and channel.
- R6: A data byte received while no running status is held produces no record.
- R7: A byte 0x80..0xF7 whose upper nibble is neither 8 nor 9 clears running status and drops any half-collected message. Data bytes that follow yield no record until the next note status byte.
- R8: Real-time bytes 0xF8..0xFF have no effect, even between the key byte and the velocity byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all record fields stay unchanged.
- R10: Records leave in arrival order. A record completed while the output is occupied waits in the holding register and is presented in the cycle after the earlier record is accepted.
- R11: If a record completes while both the output and holding registers are full and no record is accepted on that edge, the new record is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_byte | input | 8 | Received MIDI byte |
| in_stb | input | 1 | One-cycle strobe qualifying `in_byte` |
| out_ready | input | 1 | Consumer accepts the presented record |
| out_valid | output | 1 | A note record is presented |
| out_on | output | 1 | 1 = note on, 0 = note off |
| out_chan | output | 4 | MIDI channel |
| out_key | output | 7 | Note (key) number |
| out_vel | output | 7 | Velocity |

## Verification
Several corner cases are driven on purpose. A zero-velocity note-on checks that a parser ignoring R4 would report a sounding note with velocity 0. A real-time byte between key and velocity checks that a parser treating all bytes at or above 0x80 as status would lose the message. A foreign status byte in mid-message checks that a parser keeping its half-collected key would later emit a ghost record.

A stalled consumer with three completed messages exposes any holding logic that overwrites, reorders or duplicates records. Long random byte streams with random back-pressure compare every accepted record against a reference parser kept in the bench.

// File: rtl/midi_note_pkg.sv
package midi_note_pkg;
  parameter int BYTE_W = 8;
  parameter int CHAN_W = 4;
  localparam int KEY_W = BYTE_W - 1;

  typedef enum logic [1:0] {
    BK_DATA,
    BK_NOTE_STATUS,
    BK_OTHER_STATUS,
    BK_REALTIME
  } byte_kind_e;

  typedef struct packed {
    logic              on;
    logic [CHAN_W-1:0] chan;
    logic [KEY_W-1:0]  key;
    logic [KEY_W-1:0]  vel;
  } note_rec_t;
endpackage

// File: rtl/midi_rst_sync.sv
module midi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/midi_byte_classify.sv
module midi_byte_classify
  import midi_note_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output byte_kind_e        kind,
  output logic              on_status,
  output logic [CHAN_W-1:0] chan
);
  always_comb begin
    if (!byte_in[BYTE_W-1])                     kind = BK_DATA;
    else if (byte_in[BYTE_W-1 -: 5] == 5'b11111) kind = BK_REALTIME;
    else if (byte_in[BYTE_W-1 -: 3] == 3'b100)   kind = BK_NOTE_STATUS;
    else                                         kind = BK_OTHER_STATUS;
  end

  assign on_status = byte_in[BYTE_W-4];
  assign chan      = byte_in[CHAN_W-1:0];
endmodule

// File: rtl/midi_note_fsm.sv
module midi_note_fsm
  import midi_note_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [BYTE_W-1:0] byte_in,
  input  byte_kind_e        kind,
  input  logic              on_status,
  input  logic [CHAN_W-1:0] chan,
  output logic              push,
  output note_rec_t         rec
);
  logic              rs_valid_q, rs_valid_n;
  logic              rs_on_q, rs_on_n;
  logic [CHAN_W-1:0] rs_chan_q, rs_chan_n;
  logic              have_key_q, have_key_n;
  logic [KEY_W-1:0]  key_q, key_n;
  logic              state_en;
  logic              vel_zero;

  assign vel_zero = (byte_in[KEY_W-1:0] == '0);
  assign state_en = stb;

  always_comb begin
    rs_valid_n = rs_valid_q;
    rs_on_n    = rs_on_q;
    rs_chan_n  = rs_chan_q;
    have_key_n = have_key_q;
    key_n      = key_q;
    push       = 1'b0;
    rec.on     = rs_on_q & ~vel_zero;
    rec.chan   = rs_chan_q;
    rec.key    = key_q;
    rec.vel    = byte_in[KEY_W-1:0];
    if (stb) begin
      case (kind)
        BK_NOTE_STATUS: begin
          rs_valid_n = 1'b1;
          rs_on_n    = on_status;
          rs_chan_n  = chan;
          have_key_n = 1'b0;
        end
        BK_OTHER_STATUS: begin
          rs_valid_n = 1'b0;
          have_key_n = 1'b0;
        end
        BK_DATA: begin
          if (rs_valid_q) begin
            if (!have_key_q) begin
              key_n      = byte_in[KEY_W-1:0];
              have_key_n = 1'b1;
            end else begin
              push       = 1'b1;
              have_key_n = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid_q <= 1'b0;
      rs_on_q    <= 1'b0;
      rs_chan_q  <= '0;
      have_key_q <= 1'b0;
      key_q      <= '0;
    end else if (state_en) begin
      rs_valid_q <= rs_valid_n;
      rs_on_q    <= rs_on_n;
      rs_chan_q  <= rs_chan_n;
      have_key_q <= have_key_n;
      key_q      <= key_n;
    end
  end

  AST_PUSH_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (rs_valid_q && have_key_q && stb)); // R6
  AST_OTHER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && kind == BK_OTHER_STATUS) |=> (!rs_valid_q && !have_key_q)); // R7
  AST_REALTIME_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && kind == BK_REALTIME) |=> ($stable(rs_valid_q) && $stable(have_key_q) && $stable(key_q))); // R8
  AST_ZERO_VEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !(rec.on && rec.vel == '0)); // R4
endmodule

// File: rtl/midi_note_outbuf.sv
module midi_note_outbuf
  import midi_note_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  note_rec_t rec_in,
  input  logic      ready,
  output logic      valid,
  output note_rec_t rec_out
);
  note_rec_t out_q, out_n, hold_q, hold_n;
  logic      out_v_q, out_v_n, hold_v_q, hold_v_n;
  logic      out_en, hold_en, pop;

  assign pop = out_v_q & ready;

  always_comb begin
    out_n    = out_q;
    hold_n   = hold_q;
    out_v_n  = out_v_q;
    hold_v_n = hold_v_q;
    out_en   = 1'b0;
    hold_en  = 1'b0;
    if (pop) begin
      if (hold_v_q) begin
        out_n  = hold_q;
        out_en = 1'b1;
        if (push) begin
          hold_n  = rec_in;
          hold_en = 1'b1;
        end else begin
          hold_v_n = 1'b0;
        end
      end else if (push) begin
        out_n  = rec_in;
        out_en = 1'b1;
      end else begin
        out_v_n = 1'b0;
      end
    end else if (push) begin
      if (!out_v_q) begin
        out_n   = rec_in;
        out_en  = 1'b1;
        out_v_n = 1'b1;
      end else if (!hold_v_q) begin
        hold_n   = rec_in;
        hold_en  = 1'b1;
        hold_v_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q  <= 1'b0;
      hold_v_q <= 1'b0;
    end else begin
      out_v_q  <= out_v_n;
      hold_v_q <= hold_v_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_n;
  end

  assign valid   = out_v_q;
  assign rec_out = out_q;

  AST_HOLD_BEHIND_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v_q |-> out_v_q); // R10
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v_q && !ready) |=> (out_v_q && $stable(out_q))); // R9
  AST_HOLD_PROMOTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && hold_v_q) |=> out_v_q); // R10
endmodule

// File: rtl/midi_note_parser.sv
module midi_note_parser
  import midi_note_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_stb,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_on,
  output logic [CHAN_W-1:0] out_chan,
  output logic [KEY_W-1:0]  out_key,
  output logic [KEY_W-1:0]  out_vel
);
  logic              rst_n_s;
  byte_kind_e        kind;
  logic              on_status;
  logic [CHAN_W-1:0] chan;
  logic              push;
  note_rec_t         rec, rec_out;

  midi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  midi_byte_classify u_cls (
    .byte_in(in_byte), .kind(kind), .on_status(on_status), .chan(chan)
  );

  midi_note_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .stb(in_stb), .byte_in(in_byte),
    .kind(kind), .on_status(on_status), .chan(chan),
    .push(push), .rec(rec)
  );

  midi_note_outbuf u_buf (
    .clk(clk), .rst_n(rst_n_s), .push(push), .rec_in(rec),
    .ready(out_ready), .valid(out_valid), .rec_out(rec_out)
  );

  assign out_on   = rec_out.on;
  assign out_chan = rec_out.chan;
  assign out_key  = rec_out.key;
  assign out_vel  = rec_out.vel;

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> !out_valid); // R1
endmodule

// File: tb/tb_midi_note_parser.sv
module tb_midi_note_parser;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_byte;
  logic       in_stb;
  logic       out_ready;
  logic       out_valid, out_on;
  logic [3:0] out_chan;
  logic [6:0] out_key, out_vel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rmode  = 0;      // 0 always ready, 1 random, 2 stalled
  int accepted = 0;

  // reference parser state
  logic       m_rs = 1'b0;
  logic       m_on = 1'b0;
  logic [3:0] m_ch = '0;
  logic       m_have = 1'b0;
  logic [6:0] m_key = '0;
  logic       m_runs = 1'b0;
  logic [18:0] eq[$];
  string       etag[$];

  logic        prev_stall = 1'b0;
  logic [18:0] prev_rec = '0;

  always #2 clk = ~clk;

  midi_note_parser dut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_stb(in_stb),
    .out_ready(out_ready), .out_valid(out_valid), .out_on(out_on),
    .out_chan(out_chan), .out_key(out_key), .out_vel(out_vel)
  );

  task automatic chk(input string tag, input logic ok, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // reference model of one byte; returns 1 and the record when a message completes
  function automatic logic model_byte(input logic [7:0] b, output logic [18:0] r, output string tag);
    model_byte = 1'b0;
    r = '0;
    tag = "";
    if (b >= 8'hF8) begin
    end else if (b[7:4] == 4'h8 || b[7:4] == 4'h9) begin
      m_rs = 1'b1; m_on = b[4]; m_ch = b[3:0]; m_have = 1'b0; m_runs = 1'b0;
    end else if (b[7]) begin
      m_rs = 1'b0; m_have = 1'b0;
    end else if (m_rs) begin
      if (!m_have) begin
        m_key = b[6:0]; m_have = 1'b1;
      end else begin
        m_have = 1'b0;
        r = {m_on && b[6:0] != 0, m_ch, m_key, b[6:0]};
        if (m_runs)                  tag = "R5";
        else if (m_on && b[6:0] == 0) tag = "R4";
        else if (m_on)               tag = "R2";
        else                         tag = "R3";
        m_runs = 1'b1;
        model_byte = 1'b1;
      end
    end
  endfunction

  task automatic step(input logic [7:0] b, input logic s);
    logic        r;
    logic [18:0] act, rec;
    string       tag;
    @(negedge clk);
    case (rmode)
      0: r = 1'b1;
      1: r = ($urandom % 3) != 0;
      default: r = 1'b0;
    endcase
    act = {out_on, out_chan, out_key, out_vel};
    chk("R10 valid matches pending count", out_valid == (eq.size() > 0),
        {18'd0, out_valid}, {18'd0, eq.size() > 0});
    if (prev_stall)
      chk("R9 fields held under stall", out_valid && act == prev_rec, act, prev_rec);
    if (out_valid && r && eq.size() > 0) begin
      chk({etag[0], " record"}, act == eq[0], act, eq[0]);
      void'(eq.pop_front());
      void'(etag.pop_front());
      accepted++;
    end
    prev_stall = out_valid && !r;
    prev_rec   = act;
    out_ready = r;
    in_byte   = b;
    in_stb    = s;
    if (s && model_byte(b, rec, tag)) begin
      if (eq.size() < 2) begin
        eq.push_back(rec);
        etag.push_back(tag);
      end
    end
  endtask

  task automatic send(input logic [7:0] b);
    step(b, 1'b1);
    repeat ($urandom % 3) step(8'h00, 1'b0);
  endtask

  task automatic idle(input int n);
    repeat (n) step(8'h00, 1'b0);
  endtask

  task automatic expect_quiet(input string tag);
    chk(tag, !out_valid && eq.size() == 0, {18'd0, out_valid}, 19'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_byte = '0; in_stb = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid low in reset", !out_valid, {18'd0, out_valid}, 19'd0);
    rst_n = 1'b1;
    idle(4);
    expect_quiet("R1 valid low after reset");

    // R6: data before any status
    send(8'h3C); send(8'h40); idle(4);
    expect_quiet("R6 orphan data dropped");

    // R2, R5, R3, R4 directed
    send(8'h93); send(8'd60); send(8'd64); idle(3);
    send(8'd67); send(8'd96); idle(3);
    send(8'h83); send(8'd60); send(8'd32); idle(3);
    send(8'h93); send(8'd67); send(8'd0); idle(4);

    // R8: realtime inside a message
    send(8'h95); send(8'd50); send(8'hF8); send(8'hFE); send(8'd70); idle(4);

    // R7: foreign status mid-message and afterwards
    send(8'h92); send(8'd40); send(8'hB2); send(8'd41); send(8'd42); idle(4);
    expect_quiet("R7 foreign status clears");
    send(8'hF0); send(8'd10); send(8'd11); idle(3);
    expect_quiet("R7 system byte clears");

    // R10, R11: stalled consumer with three messages
    rmode = 2;
    accepted = 0;
    send(8'h9A); send(8'd1); send(8'd2); send(8'd3); send(8'd4); send(8'd5); send(8'd6);
    idle(3);
    rmode = 0;
    idle(4);
    chk("R11 third record dropped", accepted == 2, 19'(accepted), 19'd2);

    // random mix
    rmode = 1;
    for (int i = 0; i < 3000; i++) begin
      int p;
      logic [7:0] b;
      p = $urandom % 100;
      if (p < 10)      b = {3'b100, 1'($urandom), 4'($urandom)};
      else if (p < 14) b = 8'hA0 + 8'($urandom % 8'h58);
      else if (p < 18) b = 8'hF8 + 8'($urandom % 8);
      else if (p < 30) b = 8'h00;
      else             b = {1'b0, 7'($urandom)};
      send(b);
    end
    rmode = 0;
    idle(6);
    chk("R10 all records delivered", eq.size() == 0 && !out_valid, 19'(eq.size()), 19'd0);
    finish_run();
  end
endmodule